// File: doc/BRIEF.md
# DDR Rail Power-State Sequencer

This block is the digital supervisor for a memory power subsystem made of three rails: a switched main memory supply, a linear termination rail that tracks half of it, and a buffered reference rail. It takes asynchronous status flags from the analog side and synchronises them. From those flags it picks one of three operating states: fully off, standby (main and reference up, termination high-impedance), or fully running. It then drives a mode code for each rail, the enables for both main-rail gate drivers, a current-limit select for termination soft-start, and an open-drain power-good pull-down.

Two counters set the timing. The power-good hold counter delays the release of power-good until the main rail has been in regulation for a programmed time. The termination soft-start counter keeps the termination current limit at its low level until either that counter expires or the termination output reports regulation, whichever happens first. Both counters restart each time their state is entered. Each counter length is given in microseconds and converted with a clock-rate parameter.

Top module: `ddr_rail_seq`

## Requirements
- R1: The block is fully off when the logic-supply, input-supply or reference-good flag is low, or the main enable is low. In that case the other inputs have no effect. Fully off means every mode output is 0 (high-Z), both gate enables are low, the termination limit select is low and pgoodOe is 1 (power-good pulled low).
- R2: With all supply flags good, main enable high and termination enable high, main and reference report mode 1 (normal). The termination reports mode 1 once it has been activated.
- R3: With supplies good, main enable high and termination enable low, the termination mode is 0 and the reference stays at mode 1 while the main rail is active.
- R4: In standby, a high forced-PWM select sets the main mode to 2 (power-saving) and a low select keeps mode 1. In the running state the select has no effect and the main mode is 1.
- R5: The termination stays at mode 0 while the main rail has not reported in-regulation, even with termination enable high.
- R6: When the termination activates, termIlimFull is 0. It becomes 1 exactly SS_CNT cycles later if the termination in-regulation flag stays low.
- R7: termIlimFull becomes 1 before the soft-start count expires if the termination in-regulation flag rises first.
- R8: pgoodOe falls to 0 (released) exactly HOLD_CNT cycles after the main rail enters the hold state on in-regulation.
- R9: If the main in-regulation flag drops during the hold, the block goes back to ramping and the termination turns off. The hold count then restarts from zero on the next in-regulation.
- R10: A thermal fault or a latched overcurrent flag forces the fully-off sequence. When the flag clears, the block ramps up again.
- R11: On leaving an active state, all rails go to mode 0 and the gates go low one cycle before pgoodOe returns to 1.
- R12: Each input change appears at the outputs on the third rising clock edge after it is applied (two synchroniser flops plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| logicSupplyOk | input | 1 | Logic supply above its threshold |
| inputSupplyOk | input | 1 | Conversion input supply above its threshold |
| refOk | input | 1 | Internal reference settled |
| mainEn | input | 1 | Main rail enable |
| termEn | input | 1 | Termination rail enable |
| fpwmSel | input | 1 | High allows power-saving in standby, low forces PWM |
| mainInReg | input | 1 | Main rail in regulation |
| termInReg | input | 1 | Termination output in regulation |
| thermalFault | input | 1 | Over-temperature flag (with hysteresis upstream) |
| ocLatched | input | 1 | Latched main-rail overcurrent flag |
| mainMode | output | 2 | Main rail mode: 0 high-Z, 1 normal, 2 power-saving |
| refMode | output | 2 | Reference rail mode, same coding |
| termMode | output | 2 | Termination rail mode, same coding |
| termIlimFull | output | 1 | 0 soft-start current limit, 1 full limit |
| hsGateEn | output | 1 | High-side gate drive enable |
| lsGateEn | output | 1 | Low-side gate drive enable |
| pgoodOe | output | 1 | 1 pulls the open-drain power-good low |

## Verification
The assertions look only at the output ports. They take for granted that every input is a level flag that the synchronisers may see at any cycle, so they hold for any input timing: no output combination they forbid can arise from any input sequence. The stimulus changes inputs just after a falling edge and holds each pattern for at least three rising edges before it samples, so every expected value follows from the fixed three-edge latency. Timed windows are checked one cycle before and one cycle at each expected transition.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    RAIL_HIZ    = 2'd0,
    RAIL_NORMAL = 2'd1,
    RAIL_SAVE   = 2'd2
  } railMode_e;

  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_RAMP  = 3'd1,
    M_HOLD  = 3'd2,
    M_ON    = 3'd3,
    M_DRAIN = 3'd4
  } mainState_e;

  typedef enum logic [1:0] {
    T_OFF  = 2'd0,
    T_SOFT = 2'd1,
    T_FULL = 2'd2
  } termState_e;

  typedef struct packed {
    logic holdRun;
    logic ssRun;
  } strobe_t;

  localparam int FLAG_COUNT = 10;
  localparam int F_LOGIC    = 0;
  localparam int F_INPUT    = 1;
  localparam int F_REF      = 2;
  localparam int F_MAINEN   = 3;
  localparam int F_TERMEN   = 4;
  localparam int F_FPWM     = 5;
  localparam int F_MAINREG  = 6;
  localparam int F_TERMREG  = 7;
  localparam int F_THERM    = 8;
  localparam int F_OC       = 9;
endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int CNT = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic done
);
  localparam int W = (CNT < 2) ? 1 : $clog2(CNT + 1);
  localparam logic [W-1:0] LAST = W'(CNT - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/drs_datapath.sv
module drs_datapath
  import drs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CNT    = 200,
  parameter int SS_CNT      = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FLAG_COUNT-1:0] rawFlags,
  input  strobe_t               strobes,
  output logic [FLAG_COUNT-1:0] syncFlags,
  output logic                  holdDone,
  output logic                  ssDone
);
  localparam int STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [STG-1:0][FLAG_COUNT-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage <= {stage[STG-2:0], rawFlags};
    end
  end

  assign syncFlags = stage[STG-1];

  logic [1:0] runVec;
  logic [1:0] doneVec;
  assign runVec = {strobes.ssRun, strobes.holdRun};

  for (genvar i = 0; i < 2; i++) begin : g_timer
    localparam int LEN = (i == 0) ? HOLD_CNT : SS_CNT;
    drs_timer #(.CNT(LEN)) u_timer (
      .clk  (clk),
      .rstN (rstN),
      .run  (runVec[i]),
      .done (doneVec[i])
    );
  end

  assign holdDone = doneVec[0];
  assign ssDone   = doneVec[1];
endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FLAG_COUNT-1:0] flags,
  input  logic                  holdDone,
  input  logic                  ssDone,
  output strobe_t               strobes,
  output railMode_e             mainMode,
  output railMode_e             refMode,
  output railMode_e             termMode,
  output logic                  termIlimFull,
  output logic                  gateEn,
  output logic                  pgoodOe
);
  mainState_e mainState, mainNext;
  termState_e termState, termNext;
  logic       drainPg;
  logic       saveMode;

  logic supOk, mainActive, regReached, termGo;

  assign supOk = flags[F_LOGIC] & flags[F_INPUT] & flags[F_REF] & flags[F_MAINEN]
               & ~flags[F_THERM] & ~flags[F_OC];

  assign mainActive = (mainState == M_RAMP) || (mainState == M_HOLD) || (mainState == M_ON);
  assign regReached = (mainState == M_HOLD) || (mainState == M_ON);
  assign termGo     = supOk && regReached && flags[F_TERMEN];

  always_comb begin
    mainNext = mainState;
    case (mainState)
      M_OFF:   if (supOk) mainNext = M_RAMP;
      M_RAMP: begin
        if (!supOk)                mainNext = M_DRAIN;
        else if (flags[F_MAINREG]) mainNext = M_HOLD;
      end
      M_HOLD: begin
        if (!supOk)                 mainNext = M_DRAIN;
        else if (!flags[F_MAINREG]) mainNext = M_RAMP;
        else if (holdDone)          mainNext = M_ON;
      end
      M_ON:    if (!supOk) mainNext = M_DRAIN;
      M_DRAIN: mainNext = M_OFF;
      default: mainNext = M_OFF;
    endcase
  end

  always_comb begin
    termNext = termState;
    if (!termGo) begin
      termNext = T_OFF;
    end else begin
      case (termState)
        T_OFF:   termNext = T_SOFT;
        T_SOFT:  if (flags[F_TERMREG] || ssDone) termNext = T_FULL;
        T_FULL:  termNext = T_FULL;
        default: termNext = T_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainState <= M_OFF;
      termState <= T_OFF;
      drainPg   <= 1'b0;
      saveMode  <= 1'b0;
    end else begin
      mainState <= mainNext;
      termState <= termNext;
      drainPg   <= (mainState == M_ON);
      saveMode  <= ~flags[F_TERMEN] & flags[F_FPWM];
    end
  end

  assign strobes.holdRun = (mainState == M_HOLD);
  assign strobes.ssRun   = (termState == T_SOFT);

  assign mainMode     = !mainActive ? RAIL_HIZ : (saveMode ? RAIL_SAVE : RAIL_NORMAL);
  assign refMode      = mainActive ? RAIL_NORMAL : RAIL_HIZ;
  assign termMode     = (termState != T_OFF) ? RAIL_NORMAL : RAIL_HIZ;
  assign termIlimFull = (termState == T_FULL);
  assign gateEn       = mainActive;
  assign pgoodOe      = !((mainState == M_ON) || ((mainState == M_DRAIN) && drainPg));
endmodule

// File: rtl/ddr_rail_seq.sv
module ddr_rail_seq
  import drs_pkg::*;
#(
  parameter int CLK_KHZ     = 1000,
  parameter int HOLD_US     = 200,
  parameter int SS_US       = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       logicSupplyOk,
  input  logic       inputSupplyOk,
  input  logic       refOk,
  input  logic       mainEn,
  input  logic       termEn,
  input  logic       fpwmSel,
  input  logic       mainInReg,
  input  logic       termInReg,
  input  logic       thermalFault,
  input  logic       ocLatched,
  output logic [1:0] mainMode,
  output logic [1:0] refMode,
  output logic [1:0] termMode,
  output logic       termIlimFull,
  output logic       hsGateEn,
  output logic       lsGateEn,
  output logic       pgoodOe
);
  localparam int HOLD_RAW = (CLK_KHZ * HOLD_US) / 1000;
  localparam int SS_RAW   = (CLK_KHZ * SS_US) / 1000;
  localparam int HOLD_CNT = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int SS_CNT   = (SS_RAW < 1) ? 1 : SS_RAW;

  logic [FLAG_COUNT-1:0] rawFlags, syncFlags;
  strobe_t               strobes;
  logic                  holdDone, ssDone, gateEn;
  railMode_e             mainModeE, refModeE, termModeE;

  always_comb begin
    rawFlags            = '0;
    rawFlags[F_LOGIC]   = logicSupplyOk;
    rawFlags[F_INPUT]   = inputSupplyOk;
    rawFlags[F_REF]     = refOk;
    rawFlags[F_MAINEN]  = mainEn;
    rawFlags[F_TERMEN]  = termEn;
    rawFlags[F_FPWM]    = fpwmSel;
    rawFlags[F_MAINREG] = mainInReg;
    rawFlags[F_TERMREG] = termInReg;
    rawFlags[F_THERM]   = thermalFault;
    rawFlags[F_OC]      = ocLatched;
  end

  drs_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_CNT    (HOLD_CNT),
    .SS_CNT      (SS_CNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .strobes   (strobes),
    .syncFlags (syncFlags),
    .holdDone  (holdDone),
    .ssDone    (ssDone)
  );

  drs_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .flags        (syncFlags),
    .holdDone     (holdDone),
    .ssDone       (ssDone),
    .strobes      (strobes),
    .mainMode     (mainModeE),
    .refMode      (refModeE),
    .termMode     (termModeE),
    .termIlimFull (termIlimFull),
    .gateEn       (gateEn),
    .pgoodOe      (pgoodOe)
  );

  assign mainMode = mainModeE;
  assign refMode  = refModeE;
  assign termMode = termModeE;
  assign hsGateEn = gateEn;
  assign lsGateEn = gateEn;
endmodule

// File: rtl/drs_chk.sv
module drs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mainMode,
  input logic [1:0] refMode,
  input logic [1:0] termMode,
  input logic       termIlimFull,
  input logic       hsGateEn,
  input logic       lsGateEn,
  input logic       pgoodOe
);
  // R1
  off_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainMode == 2'd0) |-> (refMode == 2'd0 && termMode == 2'd0 && !hsGateEn && !lsGateEn));

  // R3
  term_needs_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termMode != 2'd0) |-> (mainMode == 2'd1 && refMode == 2'd1));

  // R4
  save_only_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainMode == 2'd2) |-> (termMode == 2'd0 && refMode == 2'd1));

  // R6
  ilim_in_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    termIlimFull |-> (termMode == 2'd1));

  // R8
  pg_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgoodOe) |-> ($past(mainMode) != 2'd0 && mainMode != 2'd0));

  // R11
  pg_after_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgoodOe) |-> (mainMode == 2'd0 && $past(mainMode) == 2'd0 && !$past(hsGateEn)));
endmodule

bind ddr_rail_seq drs_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .mainMode     (mainMode),
  .refMode      (refMode),
  .termMode     (termMode),
  .termIlimFull (termIlimFull),
  .hsGateEn     (hsGateEn),
  .lsGateEn     (lsGateEn),
  .pgoodOe      (pgoodOe)
);

// File: tb/sim_ddr_rail_seq.sv
module sim_ddr_rail_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 100;
  localparam int HOLD_CNT   = 20;
  localparam int SS_CNT     = 100;

  localparam logic [1:0] HZ = 2'd0;
  localparam logic [1:0] NM = 2'd1;
  localparam logic [1:0] SV = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic logicSupplyOk = 0, inputSupplyOk = 0, refOk = 0, mainEn = 0, termEn = 0;
  logic fpwmSel = 0, mainInReg = 0, termInReg = 0, thermalFault = 0, ocLatched = 0;
  logic [1:0] mainMode, refMode, termMode;
  logic termIlimFull, hsGateEn, lsGateEn, pgoodOe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [9:0] exp;
  } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_rail_seq #(
    .CLK_KHZ (CLK_KHZ),
    .HOLD_US (HOLD_CNT * 1000 / CLK_KHZ),
    .SS_US   (SS_CNT * 1000 / CLK_KHZ)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .logicSupplyOk(logicSupplyOk), .inputSupplyOk(inputSupplyOk), .refOk(refOk),
    .mainEn(mainEn), .termEn(termEn), .fpwmSel(fpwmSel),
    .mainInReg(mainInReg), .termInReg(termInReg),
    .thermalFault(thermalFault), .ocLatched(ocLatched),
    .mainMode(mainMode), .refMode(refMode), .termMode(termMode),
    .termIlimFull(termIlimFull), .hsGateEn(hsGateEn), .lsGateEn(lsGateEn),
    .pgoodOe(pgoodOe)
  );

  function automatic logic [9:0] ex(logic [1:0] m, logic [1:0] r, logic [1:0] t,
                                    logic il, logic g, logic pg);
    return {m, r, t, il, g, g, pg};
  endfunction

  // monitor: pops expectations and compares them with the outputs at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        logic [9:0] act;
        it  = expQ.pop_front();
        act = {mainMode, refMode, termMode, termIlimFull, hsGateEn, lsGateEn, pgoodOe};
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver: waits n rising edges, then queues the expected output word
  task automatic step(input int n, input logic [9:0] e, input string tag);
    item_t it;
    repeat (n) @(posedge clk);
    it.tag = tag;
    it.exp = e;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic allUp();
    logicSupplyOk = 1; inputSupplyOk = 1; refOk = 1; mainEn = 1;
  endtask

  initial begin
    logic [9:0] offV;
    logic [9:0] runV;
    offV = ex(HZ, HZ, HZ, 0, 0, 1);
    runV = ex(NM, NM, NM, 1, 1, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    step(1, offV, "R1 reset state");

    allUp(); termEn = 1; fpwmSel = 1;
    step(2, offV, "R12 no change before third edge");
    step(1, ex(NM, NM, HZ, 0, 1, 1), "R12 R5 ramp, termination waits");
    step(10, ex(NM, NM, HZ, 0, 1, 1), "R5 termination held off");

    mainInReg = 1;
    step(4, ex(NM, NM, NM, 0, 1, 1), "R5 R6 termination active, low limit");
    step(18, ex(NM, NM, NM, 0, 1, 1), "R8 power-good still held");
    step(1, ex(NM, NM, NM, 0, 1, 0), "R8 R2 R4 run released, fpwm ignored");
    step(80, ex(NM, NM, NM, 0, 1, 0), "R6 limit low before timeout");
    step(1, runV, "R6 full limit at timeout");

    termEn = 0;
    step(2, runV, "R12 standby not yet");
    step(1, ex(SV, NM, HZ, 0, 1, 0), "R3 R4 standby power-saving");
    fpwmSel = 0;
    step(3, ex(NM, NM, HZ, 0, 1, 0), "R4 standby forced PWM");

    termEn = 1;
    step(3, ex(NM, NM, NM, 0, 1, 0), "R7 soft-start begins");
    termInReg = 1;
    step(2, ex(NM, NM, NM, 0, 1, 0), "R7 limit still low");
    step(1, runV, "R7 early full limit");

    mainEn = 0; termEn = 0;
    step(2, runV, "R11 before shutdown");
    step(1, ex(HZ, HZ, HZ, 0, 0, 0), "R11 rails off first");
    step(1, offV, "R11 R1 power-good low after");

    termEn = 1; fpwmSel = 1;
    step(6, offV, "R1 other inputs ignored while disabled");

    mainEn = 1;
    step(10, ex(NM, NM, NM, 1, 1, 1), "R8 inside hold");
    mainInReg = 0;
    step(4, ex(NM, NM, HZ, 0, 1, 1), "R9 R5 back to ramp");
    mainInReg = 1;
    step(22, ex(NM, NM, NM, 1, 1, 1), "R9 hold restarted");
    step(1, runV, "R9 release after full hold");

    thermalFault = 1;
    step(3, ex(HZ, HZ, HZ, 0, 0, 0), "R10 thermal drain");
    step(1, offV, "R10 thermal off");
    thermalFault = 0;
    step(3, ex(NM, NM, HZ, 0, 1, 1), "R10 thermal recovery ramp");
    step(30, runV, "R2 run after thermal");

    ocLatched = 1;
    step(4, offV, "R10 overcurrent off");
    ocLatched = 0;
    step(30, runV, "R2 run after overcurrent");

    inputSupplyOk = 0;
    step(4, offV, "R1 input supply low");
    inputSupplyOk = 1;
    step(30, runV, "R2 run restored");
    refOk = 0;
    step(4, offV, "R1 reference not good");
    refOk = 1;
    step(30, runV, "R2 run restored again");
    logicSupplyOk = 0;
    step(4, offV, "R1 logic supply low");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule